// File: doc/BRIEF.md
# Cache Maintenance Operation Sequencer

This block carries out hit-based maintenance operations on one line of a set-associative write-back cache. Two operations exist: write back the line if it is dirty and then invalidate it, or invalidate it without write-back. The pipeline presents an operation together with the result of the tag lookup, which is the hit and dirty flags plus the set, way and tag of the line. The block then holds the pipeline with a stall signal for a fixed number of cycles beyond the issue cycle. That number depends on the operation and the lookup outcome.

A dirty hit of the write-back form offers the line address to the write-back buffer over a valid/ready port. The offer is made in the first stall cycle. Every cycle the buffer refuses it lengthens the stall by one, so a full buffer costs exactly its drain time. The last stall cycle of every hit carries a one-cycle invalidate strobe with the set and way to clear.

The request port is also valid/ready. `req_ready` is low for the whole stall, and a request held during that time is simply not taken. The push port follows the usual valid/ready rules: once `wb_valid` rises, it and `wb_line_addr` stay unchanged until a cycle in which `wb_ready` is high. The budgets for a clean write-back hit (3) and for an invalidate hit (2) are parameters, and both must be at least 2.

Top module: `cmo_seq`

## Requirements
- R1: After reset, `stall`, `wb_valid` and `inv_valid` are low and `req_ready` is high.
- R2: A request accepted with `req_hit` low, for either value of `req_op`, causes no stall, no push and no invalidate strobe. The next request can be taken in the following cycle.
- R3: A request with `req_op`=1 (invalidate only) that hits raises `stall` for exactly 2 cycles after the issue cycle. It never pushes, even when `req_dirty` is high.
- R4: A request with `req_op`=0 (write back and invalidate) that hits a clean line raises `stall` for exactly 3 cycles and never pushes.
- R5: A request with `req_op`=0 that hits a dirty line raises `wb_valid` in the first stall cycle and keeps it high until it is accepted. The stall lasts 3+n cycles, where n is the number of cycles in which `wb_valid` was high and `wb_ready` was low.
- R6: `wb_line_addr` carries {tag, set} of the request. It stays stable while `wb_valid` is high and `wb_ready` is low, and exactly one push is accepted per dirty write-back hit.
- R7: Each hit produces `inv_valid` for exactly one cycle, in the final stall cycle. It carries the set and way of the request.
- R8: `req_ready` is low in every stall cycle, and requests presented then are ignored. It is high again in the first cycle after `stall` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_op | input | 1 | 0 = write back and invalidate, 1 = invalidate only |
| req_hit | input | 1 | Tag lookup hit |
| req_dirty | input | 1 | Hit line is dirty |
| req_set | input | SET_W | Set index of the line |
| req_way | input | WAY_W | Way holding the line |
| req_tag | input | TAG_W | Tag of the line |
| stall | output | 1 | Pipeline hold, high for the penalty cycles |
| inv_valid | output | 1 | One-cycle invalidate strobe |
| inv_set | output | SET_W | Set to invalidate |
| inv_way | output | WAY_W | Way to invalidate |
| wb_valid | output | 1 | Dirty line offered to the write-back buffer |
| wb_ready | input | 1 | Write-back buffer has room |
| wb_line_addr | output | TAG_W+SET_W | Line address {tag, set} being pushed |

## Verification
Count the issue edge as cycle 0. The stall is then due in cycles 1 through P, the invalidate strobe in cycle P, the push offer from cycle 1 until the first cycle in which ready is high, and `req_ready` again in cycle P+1. The bench drives inputs and samples outputs at falling edges. In each cycle k after the issue edge it records `stall`, `inv_valid` and the push handshake. It then compares the cycle counts with P, which it computes from the operation, the hit and dirty flags and the number of refusals it chose to make. The sweep covers every operation, hit and dirty combination, refusal counts 0 to 5, and several set, way and tag values.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic {
    OP_WB_INV = 1'b0,
    OP_INV    = 1'b1
  } cmo_op_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cmo_budget.sv
module cmo_budget
  import cmo_pkg::*;
#(
  parameter int unsigned PEN_CLEAN = 3,
  parameter int unsigned PEN_HINV  = 2,
  parameter int unsigned CNT_W     = 2
) (
  input  logic             op,
  input  logic             hit,
  input  logic             dirty,
  output logic [CNT_W-1:0] budget,
  output logic             push_needed
);
  always_comb begin
    budget      = '0;
    push_needed = 1'b0;
    if (hit) begin
      if (cmo_op_e'(op) == OP_INV) begin
        budget = CNT_W'(PEN_HINV);
      end else begin
        budget      = CNT_W'(PEN_CLEAN);
        push_needed = dirty;
      end
    end
  end
endmodule

// File: rtl/cmo_stall_ctr.sv
module cmo_stall_ctr #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             hold,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (busy && !hold) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1)) && !hold;
endmodule

// File: rtl/cmo_wb_port.sv
module cmo_wb_port #(
  parameter int unsigned ADDR_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_line_addr,
  output logic              waiting
);
  logic pend_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (arm) begin
      pend_q <= 1'b1;
      addr_q <= arm_addr;
    end else if (pend_q && wb_ready) begin
      pend_q <= 1'b0;
    end
  end

  assign wb_valid     = pend_q;
  assign wb_line_addr = addr_q;
  assign waiting      = pend_q && !wb_ready;
endmodule

// File: rtl/cmo_seq.sv
module cmo_seq
  import cmo_pkg::*;
#(
  parameter int unsigned SETS      = 128,
  parameter int unsigned WAYS      = 4,
  parameter int unsigned TAG_W     = 24,
  parameter int unsigned PEN_CLEAN = 3,
  parameter int unsigned PEN_HINV  = 2,
  localparam int unsigned SET_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned ADDR_W   = TAG_W + SET_W,
  localparam int unsigned CNT_W    = $clog2(max2(PEN_CLEAN, PEN_HINV) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_hit,
  input  logic              req_dirty,
  input  logic [SET_W-1:0]  req_set,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              stall,
  output logic              inv_valid,
  output logic [SET_W-1:0]  inv_set,
  output logic [WAY_W-1:0]  inv_way,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_line_addr
);
  logic             accept;
  logic [CNT_W-1:0] budget;
  logic             push_needed;
  logic             busy;
  logic             last;
  logic             push_wait;
  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  cmo_budget #(
    .PEN_CLEAN (PEN_CLEAN),
    .PEN_HINV  (PEN_HINV),
    .CNT_W     (CNT_W)
  ) u_budget (
    .op          (req_op),
    .hit         (req_hit),
    .dirty       (req_dirty),
    .budget      (budget),
    .push_needed (push_needed)
  );

  cmo_stall_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (budget),
    .hold     (push_wait),
    .busy     (busy),
    .last     (last)
  );

  cmo_wb_port #(
    .ADDR_W (ADDR_W)
  ) u_wb (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (accept && push_needed),
    .arm_addr     ({req_tag, req_set}),
    .wb_ready     (wb_ready),
    .wb_valid     (wb_valid),
    .wb_line_addr (wb_line_addr),
    .waiting      (push_wait)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q <= '0;
      way_q <= '0;
    end else if (accept) begin
      set_q <= req_set;
      way_q <= req_way;
    end
  end

  assign stall     = busy;
  assign inv_valid = busy && last;
  assign inv_set   = set_q;
  assign inv_way   = way_q;
endmodule

// File: rtl/cmo_seq_chk.sv
module cmo_seq_chk #(
  parameter int unsigned ADDR_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_hit,
  input logic              stall,
  input logic              inv_valid,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_line_addr
);
  a_r2_miss_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_hit) |=> !stall);

  a_r5_push_inside_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> stall);

  a_r6_push_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line_addr)));

  a_r7_inv_ends_stall: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> (!stall && !inv_valid));

  a_r7_inv_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (stall && !wb_valid));

  a_r8_no_take_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);
endmodule

bind cmo_seq cmo_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_hit      (req_hit),
  .stall        (stall),
  .inv_valid    (inv_valid),
  .wb_valid     (wb_valid),
  .wb_ready     (wb_ready),
  .wb_line_addr (wb_line_addr)
);

// File: tb/tb_cmo_seq.sv
module tb_cmo_seq;
  localparam int SET_W = 7;
  localparam int WAY_W = 2;
  localparam int TAG_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_op = 1'b0;
  logic req_hit = 1'b0;
  logic req_dirty = 1'b0;
  logic [SET_W-1:0] req_set = '0;
  logic [WAY_W-1:0] req_way = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic stall;
  logic inv_valid;
  logic [SET_W-1:0] inv_set;
  logic [WAY_W-1:0] inv_way;
  logic wb_valid;
  logic wb_ready = 1'b0;
  logic [TAG_W+SET_W-1:0] wb_line_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmo_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_hit(req_hit), .req_dirty(req_dirty),
    .req_set(req_set), .req_way(req_way), .req_tag(req_tag),
    .stall(stall), .inv_valid(inv_valid), .inv_set(inv_set), .inv_way(inv_way),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line_addr(wb_line_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input bit op, input bit hit, input bit dirty, input int n,
                          input int set, input int way, input int tag, input bit hold_req);
    int pen = 0;
    int stalls = 0;
    int invs = 0;
    int inv_k = -1;
    int pushes = 0;
    int refusals = 0;
    int bad_inv = 0;
    int bad_addr = 0;
    int ready_in_stall = 0;
    int k = 1;
    bit push = op == 1'b0 && hit && dirty;
    if (hit) pen = op ? 2 : (dirty ? 3 + n : 3);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before issue", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_hit = hit; req_dirty = dirty;
    req_set = SET_W'(set); req_way = WAY_W'(way); req_tag = TAG_W'(tag);
    @(negedge clk);
    if (!hold_req) req_valid = 1'b0;
    else begin req_op = 1'b1; req_hit = 1'b1; end
    while (k < 40) begin
      wb_ready = wb_valid && (refusals >= n);
      #0.5;
      if (!stall) break;
      stalls++;
      if (req_ready) ready_in_stall++;
      if (wb_valid && !wb_ready) refusals++;
      if (wb_valid && wb_ready) begin
        pushes++;
        if (wb_line_addr != {TAG_W'(tag), SET_W'(set)}) bad_addr++;
      end
      if (inv_valid) begin
        invs++; inv_k = k;
        if (inv_set != SET_W'(set) || inv_way != WAY_W'(way)) bad_inv++;
      end
      @(negedge clk);
      k++;
    end
    wb_ready = 1'b0;
    req_valid = 1'b0;
    if (!hit) chk(stalls == 0, "R2 miss stall", stalls, 0);
    else if (op) chk(stalls == pen, "R3 invalidate hit stall", stalls, pen);
    else if (!dirty) chk(stalls == pen, "R4 clean hit stall", stalls, pen);
    else chk(stalls == pen, "R5 dirty hit stall 3+n", stalls, pen);
    chk(pushes == (push ? 1 : 0), "R6 push count", pushes, push ? 1 : 0);
    if (push) chk(bad_addr == 0, "R6 push address", bad_addr, 0);
    chk(invs == (hit ? 1 : 0), "R7 strobe count", invs, hit ? 1 : 0);
    if (hit) begin
      chk(inv_k == pen, "R7 strobe cycle", inv_k, pen);
      chk(bad_inv == 0, "R7 strobe set/way", bad_inv, 0);
    end
    chk(ready_in_stall == 0, "R8 ready during stall", ready_in_stall, 0);
    chk(req_ready == 1'b1, "R8 ready after stall", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(stall == 0 && wb_valid == 0 && inv_valid == 0, "R1 reset outputs",
        {stall, wb_valid, inv_valid}, 0);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    for (int op = 0; op < 2; op++)
      for (int hit = 0; hit < 2; hit++)
        for (int dirty = 0; dirty < 2; dirty++)
          for (int n = 0; n < 6; n++)
            run_case(op[0], hit[0], dirty[0], n, (n * 37 + op * 5) % 128,
                     (n + dirty) % 4, 24'h5A0000 + n * 4099 + hit, 1'b0);
    // R8: request held high through the stall is not taken twice
    run_case(1'b0, 1'b1, 1'b1, 2, 127, 3, 24'hFFFFFF, 1'b0);
    run_case(1'b1, 1'b1, 1'b0, 0, 0, 0, 24'h000001, 1'b1);
    // R2: back-to-back misses accepted on consecutive edges
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b0; req_op = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #0.5;
      chk(stall == 0 && req_ready == 1, "R2 consecutive misses", {stall, req_ready}, 1);
    end
    req_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule